// File: doc/BRIEF.md
# Saturating ALU With Sticky Saturation Flag

An 8-bit two's complement arithmetic unit for a small DSP datapath. Each cycle a 3-bit opcode selects one of these operations:
- saturating addition or subtraction of operands A and B;
- a saturating absolute value of A, of A+B or of A−B;
- clearing the saturation flag;
- doing nothing.

Sums and differences are formed exactly at extended width. The absolute value is taken from that exact value. Only then is the value clamped to the signed range −128..127.

The block keeps three status flags in registers: negative (N), zero (Z) and saturation (S). N and Z follow the most recent arithmetic result. S is sticky: a clamp sets it, and only the clear opcode resets it. This lets software run a whole block of arithmetic and test S once at the end. The result is registered and changes only on arithmetic opcodes.

Top module: `sat_alu8`

## Requirements
- R1: After reset, the outputs are result = 0, flag_n = 0, flag_z = 1 and flag_s = 0.
- R2: Opcode 1 loads result with A+B, clamped to −128..127. The value appears on the first clock edge after the opcode is applied.
- R3: Opcode 3 loads result with A−B, clamped to −128..127.
- R4: Opcode 4 loads result with |A|. |−128| clamps to 127.
- R5: Opcode 5 loads result with |A+B|, computed from the exact sum. Any magnitude above 127 clamps to 127.
- R6: Opcode 6 loads result with |A−B|, computed from the exact difference. Any magnitude above 127 clamps to 127.
- R7: On opcodes 1 and 3 to 6, flag_n becomes bit 7 of the new result and flag_z becomes 1 exactly when the new result is 0.
- R8: flag_s becomes 1 on any arithmetic opcode whose value was clamped. Otherwise it keeps its value, including through later arithmetic that does not clamp.
- R9: Opcode 7 clears flag_s and leaves result, flag_n and flag_z unchanged.
- R10: Opcodes 0 and 2 change neither result nor any flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op | input | 3 | Operation select |
| a | input | W (8) | Operand A, two's complement |
| b | input | W (8) | Operand B, two's complement |
| result | output | W (8) | Registered result |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_s | output | 1 | Sticky saturation flag |

## Verification
Every effect of an opcode, on the result and on all three flags, is due at the first rising edge after the opcode and operands are applied, and holds until the next opcode takes effect. The bench drives each operation on a falling edge and checks the outputs at the next falling edge, one edge after the capture. It updates its own model of result and flags only for operations that should change them. As a result, holds on no-op and on flag clear are checked in the same cycle grid as the arithmetic results.

// File: rtl/sat_alu8.sv
module sat_alu8 #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [2:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] result,
  output logic         flag_n,
  output logic         flag_z,
  output logic         flag_s
);
  localparam int XW = W + 2;
  localparam logic signed [XW-1:0] HI = XW'((1 << (W-1)) - 1);
  localparam logic signed [XW-1:0] LO = ~HI;

  logic signed [XW-1:0] xa, xb, sum, dif, pick, mag;
  logic abs_sel, arith, hi_ovf, lo_ovf;
  logic [W-1:0] sat_val;

  assign xa = {{2{a[W-1]}}, a};
  assign xb = {{2{b[W-1]}}, b};
  assign sum = xa + xb;
  assign dif = xa - xb;

  always_comb begin
    case (op)
      3'd1, 3'd5: pick = sum;
      3'd3, 3'd6: pick = dif;
      default:    pick = xa;
    endcase
  end

  assign abs_sel = (op == 3'd4) || (op == 3'd5) || (op == 3'd6);
  assign arith   = abs_sel || (op == 3'd1) || (op == 3'd3);
  assign mag     = (abs_sel && pick[XW-1]) ? -pick : pick;
  assign hi_ovf  = mag > HI;
  assign lo_ovf  = mag < LO;
  assign sat_val = hi_ovf ? HI[W-1:0] : lo_ovf ? LO[W-1:0] : mag[W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result <= '0;
      flag_n <= 1'b0;
      flag_z <= 1'b1;
      flag_s <= 1'b0;
    end else if (arith) begin
      result <= sat_val;
      flag_n <= sat_val[W-1];
      flag_z <= (sat_val == '0);
      if (hi_ovf || lo_ovf) flag_s <= 1'b1;
    end else if (op == 3'd7) begin
      flag_s <= 1'b0;
    end
  end

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 3'd0 || op == 3'd2) |=> ($stable(result) && $stable(flag_n) &&
                                    $stable(flag_z) && $stable(flag_s)));

  p_clear_s_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 3'd7) |=> (!flag_s && $stable(result) && $stable(flag_n) && $stable(flag_z)));

  p_sticky_s_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_s && op != 3'd7) |=> flag_s);

  p_flags_track_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_n == result[W-1]) && (flag_z == (result == '0)));

  p_abs_nonneg_r4: assert property (@(posedge clk) disable iff (!rst_n)
    abs_sel |=> !flag_n);
endmodule

// File: tb/sat_alu8_test.sv
module sat_alu8_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] op = 3'd0;
  logic [7:0] a = 8'd0, b = 8'd0;
  logic [7:0] result;
  logic flag_n, flag_z, flag_s;

  int checks = 0, fails = 0;
  logic [7:0] m_res = 8'd0;
  logic m_n = 1'b0, m_z = 1'b1, m_s = 1'b0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sat_alu8 uut (.clk(clk), .rst_n(rst_n), .op(op), .a(a), .b(b),
                .result(result), .flag_n(flag_n), .flag_z(flag_z), .flag_s(flag_s));

  function automatic string tag_of(input logic [2:0] o);
    case (o)
      3'd1: return "R2";
      3'd3: return "R3";
      3'd4: return "R4";
      3'd5: return "R5";
      3'd6: return "R6";
      3'd7: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic model(input logic [2:0] o, input logic [7:0] x, input logic [7:0] y);
    int va, vb, v;
    va = $signed(x);
    vb = $signed(y);
    case (o)
      3'd1: v = va + vb;
      3'd3: v = va - vb;
      3'd4: v = (va < 0) ? -va : va;
      3'd5: v = (va + vb < 0) ? -(va + vb) : va + vb;
      3'd6: v = (va - vb < 0) ? -(va - vb) : va - vb;
      default: v = 0;
    endcase
    if (o == 3'd1 || (o >= 3'd3 && o <= 3'd6)) begin
      if (v > 127) begin v = 127; m_s = 1'b1; end
      else if (v < -128) begin v = -128; m_s = 1'b1; end
      m_res = v[7:0];
      m_n = m_res[7];
      m_z = (m_res == 8'd0);
    end else if (o == 3'd7) begin
      m_s = 1'b0;
    end
  endtask

  task automatic check(input string tag);
    checks++;
    if (result !== m_res || flag_n !== m_n || flag_z !== m_z || flag_s !== m_s) begin
      fails++;
      $display("FAIL %s: got res=%0d n=%b z=%b s=%b, expected res=%0d n=%b z=%b s=%b",
               tag, $signed(result), flag_n, flag_z, flag_s,
               $signed(m_res), m_n, m_z, m_s);
    end
  endtask

  task automatic run(input logic [2:0] o, input logic [7:0] x, input logic [7:0] y,
                     input string extra);
    @(negedge clk);
    op = o; a = x; b = y;
    model(o, x, y);
    @(negedge clk);
    op = 3'd0;
    check({tag_of(o), extra});
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (2) @(negedge clk);
    check("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release");
    run(3'd1, 8'd100, 8'd20, " add plain R7");
    run(3'd1, 8'd127, 8'd1, " add clamp high R8");
    run(3'd1, 8'd3, 8'd4, " add no clamp keeps S R8");
    run(3'd7, 8'd9, 8'd9, " clear S");
    run(3'd1, 8'h80, 8'hFF, " add clamp low R8");
    run(3'd7, 8'd0, 8'd0, " clear S again");
    run(3'd3, 8'd5, 8'd5, " zero R7");
    run(3'd3, 8'h80, 8'd1, " sub clamp low");
    run(3'd3, 8'd127, 8'hFF, " sub clamp high");
    run(3'd7, 8'd0, 8'd0, " clear");
    run(3'd4, 8'h80, 8'd0, " abs of -128 clamps");
    run(3'd4, 8'hF6, 8'd0, " abs of -10");
    run(3'd5, 8'h80, 8'h80, " abs of -256 clamps");
    run(3'd6, 8'h80, 8'd127, " abs of -255 clamps");
    run(3'd7, 8'd0, 8'd0, " clear");
    run(3'd6, 8'd10, 8'd30, " abs diff 20");
    run(3'd5, 8'hF0, 8'd4, " abs sum 12");
    run(3'd3, 8'hF0, 8'd4, " negative R7");
    run(3'd0, 8'd1, 8'd1, " op0 no change");
    run(3'd2, 8'd50, 8'd50, " op2 no change");
    run(3'd7, 8'd0, 8'd0, " keeps result N Z");
    for (int i = 0; i < 400; i++) begin
      logic [2:0] o;
      o = 3'($urandom_range(0, 7));
      run(o, 8'($urandom), 8'($urandom), " random");
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule